// File: doc/BRIEF.md
# Off-State Load Fault Detector

This block classifies the load on an idle bridge output. It takes two threshold comparator flags from the disabled output pair and decides whether the load looks healthy, shorted to ground, open, or shorted to the supply rail. A detected fault is counted only when the same fault type persists across a programmable number of clock cycles. A confirmed fault then sets one sticky fault bit, and that bit stays set until software pulses the clear input.

The comparator flags are asynchronous to the block clock, so they pass through a synchronizer before they are decoded. The decoded live status is always visible on `status_o`. Detection runs only while at least one of the two enable pins is high. Every change of the enable pair out of all-high or out of all-low re-arms the persistence timer. This gives energy stored in the load time to decay before the outputs are judged. The first fault that is latched blocks every later fault until the next clear.

Top module: `offload_fault_det`

## Requirements
- R1: `status_o` decodes the synchronized flags (hi = above the upper threshold, lo = above the lower threshold) as 0 = normal (hi 0, lo 1), 1 = short to ground (hi 0, lo 0), 2 = open load (hi 1, lo 0) and 3 = short to supply (hi 1, lo 1). A flag change reaches `status_o` after exactly two rising clock edges.
- R2: With the enables active and steady, a fault status that first shows on `status_o` after edge E sets its fault bit at edge E+2+`filt_len_i` and not earlier.
- R3: When the decoded fault type changes, or returns to normal, the persistence count restarts. A new type is latched only at its own first-seen edge +2+`filt_len_i`.
- R4: While both enable pins are 0, no fault bit is set, whatever the flags show.
- R5: An enable change that leaves the state where both pins were 1, or leaves the state where both pins were 0, re-arms the filter at that edge. A fault then latches no earlier than that edge +2+`filt_len_i`.
- R6: At most one fault bit is set at a time. While any bit is set and no clear is given, the bits do not change, even if a different fault persists.
- R7: A clear pulse zeroes all fault bits at the edge where it is sampled. If the fault is still present, it is latched again only at that edge +2+`filt_len_i`.
- R8: If a clear and a latch event fall on the same edge, the clear wins and the bits are 0 after that edge.
- R9: After reset, all fault bits are 0 and `status_o` reads normal (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_a_i | input | 1 | First bridge enable pin |
| en_b_i | input | 1 | Second bridge enable pin |
| hi_cmp_i | input | 1 | Output above upper (three-quarter supply) threshold, asynchronous |
| lo_cmp_i | input | 1 | Output above lower (quarter supply) threshold, asynchronous |
| clr_i | input | 1 | Clear strobe for the fault bits |
| filt_len_i | input | CNT_W | Persistence length in clock cycles |
| flt_gnd_o | output | 1 | Latched short-to-ground fault |
| flt_open_o | output | 1 | Latched open-load fault |
| flt_supply_o | output | 1 | Latched short-to-supply fault |
| status_o | output | 2 | Live decoded load status |

## Verification
The hardest situation to reach is a clear that lands on the exact edge where a still-present fault would be latched again. The bench first latches a fault and clears it while the fault is still present. It then counts edges from that clear and raises a second clear exactly `filt_len_i`+2 edges later, which forces the collision. The filter re-arm cases are handled the same way. A fault type swap, or an enable move out of all-high, is placed a few edges into a running filter window. The bench then checks that the latch moves to the later edge the requirement predicts, and does not occur at the earlier one.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

   typedef enum logic [1:0] {
      LD_NORMAL = 2'd0,
      LD_GND    = 2'd1,
      LD_OPEN   = 2'd2,
      LD_SUPPLY = 2'd3
   } load_state_e;

   localparam int unsigned FAULT_KINDS = 3;

   function automatic load_state_e classify(input logic hi, input logic lo);
      load_state_e st;
      case ({hi, lo})
         2'b01:   st = LD_NORMAL;
         2'b00:   st = LD_GND;
         2'b10:   st = LD_OPEN;
         default: st = LD_SUPPLY;
      endcase
      return st;
   endfunction

endpackage

// File: rtl/ofd_sync.sv
module ofd_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "ofd_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            chain_q[s] <= RST_VAL;
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ofd_filter.sv
module ofd_filter
   import ofd_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  load_state_e      state_i,
   input  logic             active_i,
   input  logic             rearm_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             confirm_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   load_state_e      seen_q;
   logic             holding;

   // the same fault type seen in the previous cycle, and nothing re-armed the window
   assign holding = active_i && !rearm_i && (state_i != LD_NORMAL) && (state_i == seen_q);
   assign confirm_o = holding && (cnt_q >= len_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         seen_q <= LD_NORMAL;
      end else if (!active_i || rearm_i) begin
         cnt_q  <= '0;
         seen_q <= LD_NORMAL;
      end else if (holding) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q  <= '0;
         seen_q <= state_i;
      end
   end
endmodule

// File: rtl/ofd_latch.sv
module ofd_latch
   import ofd_pkg::*;
(
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   confirm_i,
   input  load_state_e            state_i,
   input  logic                   clr_i,
   output logic [FAULT_KINDS-1:0] bits_o
);
   logic [FAULT_KINDS-1:0] set_vec;

   always_comb begin
      set_vec = '0;
      case (state_i)
         LD_GND:    set_vec[0] = 1'b1;
         LD_OPEN:   set_vec[1] = 1'b1;
         LD_SUPPLY: set_vec[2] = 1'b1;
         default:   set_vec    = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bits_o <= '0;
      end else if (clr_i) begin
         bits_o <= '0;
      end else if (confirm_i && (bits_o == '0)) begin
         bits_o <= set_vec;
      end
   end
endmodule

// File: rtl/offload_fault_det.sv
module offload_fault_det
   import ofd_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_a_i,
   input  logic             en_b_i,
   input  logic             hi_cmp_i,
   input  logic             lo_cmp_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] filt_len_i,
   output logic             flt_gnd_o,
   output logic             flt_open_o,
   output logic             flt_supply_o,
   output logic [1:0]       status_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      initial $fatal(1, "offload_fault_det: CNT_W out of range 2..32");
   end

   logic        hi_s, lo_s;
   load_state_e state;
   logic [1:0]  en_q;
   logic        active, restart, rearm, confirm;
   logic [FAULT_KINDS-1:0] bits;

   ofd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hi (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hi_cmp_i), .q_o(hi_s)
   );
   ofd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lo (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lo_cmp_i), .q_o(lo_s)
   );

   assign state = classify(hi_s, lo_s);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 2'b00;
      else         en_q <= {en_a_i, en_b_i};
   end

   assign active  = en_a_i || en_b_i;
   assign restart = ((en_q == 2'b11) && ({en_a_i, en_b_i} != 2'b11)) ||
                    ((en_q == 2'b00) && ({en_a_i, en_b_i} != 2'b00));
   assign rearm   = restart || clr_i;

   ofd_filter #(.CNT_W(CNT_W)) u_filter (
      .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .active_i(active),
      .rearm_i(rearm), .len_i(filt_len_i), .confirm_o(confirm)
   );

   ofd_latch u_latch (
      .clk_i(clk_i), .rst_ni(rst_ni), .confirm_i(confirm), .state_i(state),
      .clr_i(clr_i), .bits_o(bits)
   );

   assign flt_gnd_o    = bits[0];
   assign flt_open_o   = bits[1];
   assign flt_supply_o = bits[2];
   assign status_o     = state;
endmodule

// File: rtl/offload_fault_det_chk.sv
module offload_fault_det_chk
   import ofd_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_a_i,
   input logic             en_b_i,
   input logic             hi_cmp_i,
   input logic             lo_cmp_i,
   input logic             clr_i,
   input logic [CNT_W-1:0] filt_len_i,
   input logic             flt_gnd_o,
   input logic             flt_open_o,
   input logic             flt_supply_o,
   input logic [1:0]       status_o
);
   logic [2:0] bits;
   assign bits = {flt_supply_o, flt_open_o, flt_gnd_o};

   // R6
   one_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bits));

   // R6
   lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((bits != 3'b000) && !clr_i) |=> (bits == $past(bits)));

   // R7
   clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (bits == 3'b000));

   // R4
   idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_a_i && !en_b_i && (bits == 3'b000)) |=> (bits == 3'b000));

   // R1
   gnd_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flt_gnd_o) |-> ($past(status_o) == LD_GND));

   // R1
   open_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flt_open_o) |-> ($past(status_o) == LD_OPEN));

   // R1
   supply_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flt_supply_o) |-> ($past(status_o) == LD_SUPPLY));
endmodule

bind offload_fault_det offload_fault_det_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .en_a_i(en_a_i), .en_b_i(en_b_i),
   .hi_cmp_i(hi_cmp_i), .lo_cmp_i(lo_cmp_i), .clr_i(clr_i), .filt_len_i(filt_len_i),
   .flt_gnd_o(flt_gnd_o), .flt_open_o(flt_open_o), .flt_supply_o(flt_supply_o),
   .status_o(status_o)
);

// File: tb/offload_fault_det_tb_top.sv
module offload_fault_det_tb_top;
   localparam int CW = 16;
   localparam int L  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_a = 1'b0, en_b = 1'b0, hi = 1'b0, lo = 1'b1, clr = 1'b0;
   logic [CW-1:0] flen = CW'(L);
   logic f_gnd, f_open, f_sup;
   logic [1:0] st;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   offload_fault_det #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_a_i(en_a), .en_b_i(en_b),
      .hi_cmp_i(hi), .lo_cmp_i(lo), .clr_i(clr), .filt_len_i(flen),
      .flt_gnd_o(f_gnd), .flt_open_o(f_open), .flt_supply_o(f_sup),
      .status_o(st)
   );

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk_bits(input logic [2:0] exp, input string req);
      n_run++;
      if ({f_sup, f_open, f_gnd} !== exp) begin
         n_fail++;
         $display("FAIL %s bits act=%b exp=%b", req, {f_sup, f_open, f_gnd}, exp);
      end
   endtask

   task automatic chk_st(input logic [1:0] exp, input string req);
      n_run++;
      if (st !== exp) begin
         n_fail++;
         $display("FAIL %s status act=%0d exp=%0d", req, st, exp);
      end
   endtask

   task automatic pulse_clr();
      clr = 1'b1;
      edges(1);
      clr = 1'b0;
   endtask

   task automatic prep(input logic ea, input logic eb);
      hi = 1'b0; lo = 1'b1; en_a = ea; en_b = eb;
      edges(3);
      pulse_clr();
      edges(4);
   endtask

   task automatic t_reset();
      chk_bits(3'b000, "R9");
      chk_st(2'd0, "R9");
   endtask

   task automatic t_decode();
      prep(1'b0, 1'b0);
      hi = 1'b0; lo = 1'b0; edges(1); chk_st(2'd0, "R1 one edge");
      edges(1); chk_st(2'd1, "R1 gnd");
      hi = 1'b1; lo = 1'b0; edges(2); chk_st(2'd2, "R1 open");
      hi = 1'b1; lo = 1'b1; edges(2); chk_st(2'd3, "R1 supply");
      hi = 1'b0; lo = 1'b1; edges(2); chk_st(2'd0, "R1 normal");
      chk_bits(3'b000, "R4 idle");
   endtask

   task automatic t_timing();
      prep(1'b0, 1'b1);
      hi = 1'b0; lo = 1'b0;
      edges(3 + L); chk_bits(3'b000, "R2 early");
      edges(1);     chk_bits(3'b001, "R2 latch gnd");
   endtask

   task automatic t_lockout();
      hi = 1'b1; lo = 1'b1;
      edges(L + 10);
      chk_bits(3'b001, "R6 lockout");
      chk_st(2'd3, "R6 live status");
   endtask

   task automatic t_clear();
      pulse_clr();
      chk_bits(3'b000, "R7 cleared");
      edges(1 + L); chk_bits(3'b000, "R7 refilter early");
      edges(1);     chk_bits(3'b100, "R7 relatch supply");
      pulse_clr();
      edges(1 + L);
      clr = 1'b1; edges(1); clr = 1'b0;
      chk_bits(3'b000, "R8 clear wins");
      edges(1 + L); chk_bits(3'b000, "R8 rearmed early");
      edges(1);     chk_bits(3'b100, "R8 relatch");
   endtask

   task automatic t_type_change();
      prep(1'b1, 1'b0);
      hi = 1'b0; lo = 1'b0;
      edges(5);
      hi = 1'b1; lo = 1'b0;
      edges(8); chk_bits(3'b000, "R3 early");
      edges(1); chk_bits(3'b010, "R3 latch open");
   endtask

   task automatic t_enable_idle();
      prep(1'b0, 1'b0);
      hi = 1'b0; lo = 1'b0;
      edges(20); chk_bits(3'b000, "R4 both low");
      en_a = 1'b1;
      edges(L + 2); chk_bits(3'b000, "R5 leave 00 early");
      edges(1);     chk_bits(3'b001, "R5 leave 00 latch");
   endtask

   task automatic t_enable_high();
      prep(1'b1, 1'b1);
      hi = 1'b1; lo = 1'b1;
      edges(4);
      en_a = 1'b0;
      edges(L + 2); chk_bits(3'b000, "R5 leave 11 early");
      edges(1);     chk_bits(3'b100, "R5 leave 11 latch");
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      t_reset();
      t_decode();
      t_timing();
      t_lockout();
      t_clear();
      t_type_change();
      t_enable_idle();
      t_enable_high();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule